// File: doc/BRIEF.md
# Bit-Addressable Parallel I/O Port

This block is an 8-bit general-purpose I/O port for a chip's peripheral bus. Software moves individual output bits by writing a mask to a set register or to a clear register, so no read-modify-write is needed to change one pin. A direction register decides which pins are driven. An assignment register hands each pin either to the port's own output logic or to an on-chip peripheral function, for example the select line of a serial interface. A pin that is not driven floats, and its level then comes from an outside pull resistor.

Pin levels are passed through a two-stage synchronizer before they can be read. Writes use a one-hot strobe vector with one strobe per register, all sharing one data bus. The strobe for the set register and the strobe for the clear register may be raised in the same cycle. Reads are combinational and select one of four views with a 2-bit code.

Top module: `pio_port`

## Requirements
- R1: After reset the output latch, the direction register and the assignment register are all 0, so every pin is an undriven GPIO pin (`pin_oe` = 0).
- R2: When `wr_sel[0]` (set) is high, every output latch bit whose `wr_data` bit is 1 becomes 1 at the next clock edge. All other bits keep their value. With neither set nor clear strobed, the latch holds.
- R3: When `wr_sel[1]` (clear) is high, every output latch bit whose `wr_data` bit is 0 becomes 0 at the next clock edge. Bits written as 1 keep their value.
- R4: When set and clear are strobed in the same cycle, the clear is applied after the set. The latch then equals `wr_data`.
- R5: For a pin assigned to GPIO, `pin_oe` equals its direction bit (1 drives, 0 tri-states) and `pin_out` equals its output latch bit.
- R6: For a pin whose assignment bit is 1, `pin_out` and `pin_oe` follow `alt_out` and `alt_oe`. A 0 assignment bit gives the pin to GPIO.
- R7: Read code 0 returns the pin levels as sampled through two flops. A change on `pin_in` appears after the second rising edge, not after the first.
- R8: Read codes 1, 2 and 3 return the output latch, the direction register and the assignment register.
- R9: `wr_sel[2]` loads the direction register and `wr_sel[3]` loads the assignment register with `wr_data` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_sel | input | 4 | Write strobes: bit0 set, bit1 clear, bit2 direction, bit3 assignment |
| wr_data | input | 8 | Write data shared by all strobes |
| rd_sel | input | 2 | Read view: 0 pins, 1 latch, 2 direction, 3 assignment |
| rd_data | output | 8 | Selected read view |
| alt_out | input | 8 | Peripheral function output levels |
| alt_oe | input | 8 | Peripheral function output enables |
| pin_in | input | 8 | Levels seen at the pads |
| pin_out | output | 8 | Levels driven to the pads |
| pin_oe | output | 8 | Pad drive enables |

## Verification
The latch properties assume that `wr_sel` and `wr_data` are stable across each rising edge. The bench meets this by changing every input only on falling edges. They also assume that the latch changes only through the set and clear strobes, so the bench never leaves reset in the middle of a sequence it is checking. `pin_in` is taken to be asynchronous, so nothing is asserted about read code 0. The bench instead checks the two-edge delay at the ports, holding `pin_in` steady across the observation window.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        RD_PINS  = 2'd0,
        RD_LATCH = 2'd1,
        RD_DIR   = 2'd2,
        RD_ASSIGN= 2'd3
    } rd_view_e;

    localparam int WS_SET    = 0;
    localparam int WS_CLR    = 1;
    localparam int WS_DIR    = 2;
    localparam int WS_ASSIGN = 3;
    localparam int NUM_WS    = 4;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WS-1:0] wr_sel,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      asg_q
);
    logic [W-1:0] out_d;

    // set first, clear last: clear has priority on shared bits
    always_comb begin
        out_d = out_q;
        if (wr_sel[WS_SET]) out_d = out_d | wr_data;
        if (wr_sel[WS_CLR]) out_d = out_d & wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
            asg_q <= '0;
        end else begin
            out_q <= out_d;
            if (wr_sel[WS_DIR])    dir_q <= wr_data;
            if (wr_sel[WS_ASSIGN]) asg_q <= wr_data;
        end
    end
endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] gpio_out,
    input  logic [W-1:0] gpio_dir,
    input  logic [W-1:0] assign_alt,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pad_out[i] = assign_alt[i] ? alt_out[i] : gpio_out[i];
        assign pad_oe[i]  = assign_alt[i] ? alt_oe[i]  : gpio_dir[i];
    end
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WS-1:0] wr_sel,
    input  logic [W-1:0]      wr_data,
    input  logic [1:0]        rd_sel,
    output logic [W-1:0]      rd_data,
    input  logic [W-1:0]      alt_out,
    input  logic [W-1:0]      alt_oe,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe
);
    logic [W-1:0] out_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] asg_q;
    logic [W-1:0] pins_sync;
    rd_view_e     view;

    pio_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .asg_q   (asg_q)
    );

    pio_sync #(.W(W), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    pio_pad_mux #(.W(W)) u_mux (
        .gpio_out   (out_q),
        .gpio_dir   (dir_q),
        .assign_alt (asg_q),
        .alt_out    (alt_out),
        .alt_oe     (alt_oe),
        .pad_out    (pin_out),
        .pad_oe     (pin_oe)
    );

    assign view = rd_view_e'(rd_sel);

    always_comb begin
        unique case (view)
            RD_PINS:   rd_data = pins_sync;
            RD_LATCH:  rd_data = out_q;
            RD_DIR:    rd_data = dir_q;
            RD_ASSIGN: rd_data = asg_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   wr_sel,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] out_q,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] asg_q,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] alt_out,
    input logic [W-1:0] alt_oe
);
    AST_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[0] && !wr_sel[1]) |=> out_q == ($past(out_q) | $past(wr_data))); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sel[0] && !wr_sel[1]) |=> $stable(out_q)); // R2
    AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[1] && !wr_sel[0]) |=> out_q == ($past(out_q) & $past(wr_data))); // R3
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[0] && wr_sel[1]) |=> out_q == $past(wr_data)); // R4
    AST_GPIO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe ^ dir_q) & ~asg_q) == '0); // R5
    AST_ALT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_out ^ alt_out) | (pin_oe ^ alt_oe)) & asg_q) == '0); // R6
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[2] |=> dir_q == $past(wr_data)); // R9
endmodule

bind pio_port pio_port_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .asg_q   (asg_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .alt_out (alt_out),
    .alt_oe  (alt_oe)
);

// File: tb/pio_port_bench.sv
module pio_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic [7:0] alt_out = '0;
    logic [7:0] alt_oe = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pio_port u_pio_port (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {strobes, data, expected latch after the edge}; latch starts at 00
    localparam logic [19:0] VEC [8] = '{
        {4'b0001, 8'hA5, 8'hA5},   // R2 set
        {4'b0001, 8'h0F, 8'hAF},   // R2 set, others kept
        {4'b0010, 8'hF0, 8'hA0},   // R3 clear zeros
        {4'b0010, 8'hFF, 8'hA0},   // R3 all ones: no change
        {4'b0011, 8'h3C, 8'h3C},   // R4 both, clear wins
        {4'b0000, 8'hFF, 8'h3C},   // R2 hold
        {4'b0001, 8'h00, 8'h3C},   // R2 set with zeros
        {4'b0010, 8'h00, 8'h00}    // R3 clear all
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_sel = '0;
    endtask

    initial begin
        #20000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, still in reset
        rd_sel = 2'd1; #1 chk("R1 latch", rd_data, 8'h00);
        rd_sel = 2'd2; #1 chk("R1 dir", rd_data, 8'h00);
        rd_sel = 2'd3; #1 chk("R1 assign", rd_data, 8'h00);
        chk("R1 pin_oe", pin_oe, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd_sel = 2'd1; #1;
            chk($sformatf("R2/R3/R4 vector %0d", i), rd_data, VEC[i][7:0]);
        end

        // R9 direction and R5 GPIO drive
        wr(4'b0001, 8'h5A);
        wr(4'b0100, 8'h0F);
        rd_sel = 2'd2; #1 chk("R9 dir readback", rd_data, 8'h0F);
        chk("R5 pin_oe from dir", pin_oe, 8'h0F);
        chk("R5 pin_out from latch", pin_out, 8'h5A);

        // R6 peripheral assignment on upper nibble
        alt_out = 8'hC3; alt_oe = 8'h30;
        wr(4'b1000, 8'hF0);
        rd_sel = 2'd3; #1 chk("R8 assign readback", rd_data, 8'hF0);
        chk("R6 pin_out mixed", pin_out, 8'hCA);
        chk("R6 pin_oe mixed", pin_oe, 8'h3F);
        wr(4'b1000, 8'h00);
        chk("R6 back to GPIO", pin_out, 8'h5A);
        rd_sel = 2'd1; #1 chk("R8 latch view", rd_data, 8'h5A);

        // R7 two-flop sampling
        rd_sel = 2'd0;
        @(negedge clk); pin_in = 8'h96;
        @(negedge clk); chk("R7 after one edge", rd_data, 8'h00);
        @(negedge clk); chk("R7 after two edges", rd_data, 8'h96);
        pin_in = 8'h3E;
        @(negedge clk); @(negedge clk); chk("R7 second pattern", rd_data, 8'h3E);

        // R1 reset again clears everything
        rst_n = 1'b0; #1;
        rd_sel = 2'd1; #1 chk("R1 latch after reset", rd_data, 8'h00);
        chk("R1 pin_oe after reset", pin_oe, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule